// File: doc/BRIEF.md
# Planar VRAM Read-Format Unit

This unit serves CPU reads from a four-plane video memory that sits on a bus of its own. The CPU cannot reach that memory directly. It writes a format byte that says what a read should return, then raises a read request. The unit fetches the plane bytes it needs from memory, but only in cycles that display refresh leaves free. It then hands back one assembled byte together with a one-cycle acknowledge.

There are two kinds of read. A single-plane read returns the raw byte of one plane. A colour-search read compares every enabled plane at once and returns a byte with a 1 at each pixel whose colour equals a target. The target is given by the plane bits of the format byte. Two things decide which planes may take part: the display mode input and a frame-select bit. A further input says whether the upper two planes are fitted. Planes that may not take part are ignored in both kinds of read.

Top module: `vram_readfmt`

## Requirements
- R1: After reset the format byte is 0x00, `rd_ack` and `mem_en` are low, and a read issued without a prior format write returns 0x00 without any memory access.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` as the format byte. Bit 7 selects colour search (1) or single-plane read (0). Bit 4 selects frame B (1) or frame A (0). Bits 3:0 are the plane bits for planes I (bit 0), II (bit 1), III (bit 2) and IV (bit 3). The byte is sampled when a request is accepted.
- R3: In single-plane mode, when exactly one plane bit lies inside the allowed set, a read returns that plane's stored byte after exactly one memory access.
- R4: In single-plane mode, when zero or several plane bits lie inside the allowed set, a read returns 0x00 and makes no memory access.
- R5: In search mode, result bit j is 1 exactly when, for every allowed plane p, bit j of plane p equals plane bit p. Each allowed plane is fetched once.
- R6: In mode 0 (320x200 four colours), the allowed set is planes I and II for frame A and planes III and IV for frame B.
- R7: In mode 1 (640x200 one colour), the allowed set is plane I for frame A and plane II for frame B.
- R8: In mode 2 (640x200 four colours), the allowed set is planes I and III whatever the frame bit; bits for II and IV are ignored.
- R9: In mode 3 (320x200 sixteen colours), all four planes are allowed.
- R10: `mem_en` is never high while `mem_busy` is high. Memory data is taken from `mem_rdata` one cycle after the access.
- R11: `rd_ack` is a one-cycle pulse with the result on `rd_data`. A request raised while a read is in progress is ignored. `rd_ack` never comes in the cycle right after a memory access.
- R12: With `hi_fitted` low, planes III and IV leave the allowed set and are never accessed. A search whose allowed set is empty returns 0x00 without access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Format byte write strobe |
| cfg_wdata | input | 8 | Format byte value |
| mode | input | 2 | Display mode |
| hi_fitted | input | 1 | Planes III and IV are present |
| rd_req | input | 1 | CPU read request pulse |
| rd_ack | output | 1 | Result valid pulse |
| rd_data | output | 8 | Read result |
| mem_busy | input | 1 | Display owns the memory this cycle |
| mem_en | output | 1 | Memory read strobe |
| mem_plane | output | 2 | Plane index of the access |
| mem_rdata | input | 8 | Memory data, one cycle after the strobe |

## Verification
The hardest case is a four-plane search that runs while display refresh takes most memory cycles. In that case captures and new accesses overlap and stall at random points, and a second request arrives in the middle. The bench holds `mem_busy` high three cycles out of four. It then issues a full search and pulses the request again partway through. It checks that exactly one acknowledge comes back and that the byte matches. It also counts strobes per read to confirm that no plane is fetched twice or fetched needlessly.

// File: rtl/vram_readfmt_pkg.sv
package vram_readfmt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } rf_state_e;

    typedef enum logic [1:0] {
        MD_LO4  = 2'd0,
        MD_HI1  = 2'd1,
        MD_HI4  = 2'd2,
        MD_LO16 = 2'd3
    } disp_mode_e;

    localparam int CFG_SRCH_BIT  = 7;
    localparam int CFG_FRAME_BIT = 4;
endpackage

// File: rtl/vram_readfmt_planesel.sv
module vram_readfmt_planesel
    import vram_readfmt_pkg::*;
#(
    parameter int PLANES     = 4,
    parameter int LOW_PLANES = 2
) (
    input  logic [1:0]        mode,
    input  logic              frame_b,
    input  logic              hi_fitted,
    output logic [PLANES-1:0] allow
);
    logic [PLANES-1:0] base;

    always_comb begin
        base = '0;
        unique case (disp_mode_e'(mode))
            MD_LO4: begin
                base[0] = !frame_b;
                base[1] = !frame_b;
                base[2] = frame_b;
                base[3] = frame_b;
            end
            MD_HI1: begin
                base[0] = !frame_b;
                base[1] = frame_b;
            end
            MD_HI4: begin
                base[0] = 1'b1;
                base[2] = 1'b1;
            end
            default: base = '1;
        endcase
        allow = base;
        for (int i = LOW_PLANES; i < PLANES; i++) begin
            if (!hi_fitted) allow[i] = 1'b0;
        end
    end
endmodule

// File: rtl/vram_readfmt_merge.sv
module vram_readfmt_merge #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] acc,
    input  logic [PIX_W-1:0] data,
    input  logic             tgt,
    input  logic             srch,
    output logic [PIX_W-1:0] result
);
    always_comb begin
        if (srch) result = acc & ~(data ^ {PIX_W{tgt}});
        else      result = data;
    end
endmodule

// File: rtl/vram_readfmt.sv
module vram_readfmt
    import vram_readfmt_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int PLANES = 4,
    parameter int CFG_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CFG_W-1:0]          cfg_wdata,
    input  logic [1:0]                mode,
    input  logic                      hi_fitted,
    input  logic                      rd_req,
    output logic                      rd_ack,
    output logic [PIX_W-1:0]          rd_data,
    input  logic                      mem_busy,
    output logic                      mem_en,
    output logic [$clog2(PLANES)-1:0] mem_plane,
    input  logic [PIX_W-1:0]          mem_rdata
);
    localparam int PIDX_W = $clog2(PLANES);

    typedef struct packed {
        rf_state_e         st;
        logic [CFG_W-1:0]  cfg;
        logic [PLANES-1:0] pend;
        logic [PLANES-1:0] tgt;
        logic              srch;
        logic [PIX_W-1:0]  acc;
        logic              cap;
        logic [PIDX_W-1:0] cap_plane;
    } rf_regs_t;

    rf_regs_t r_q, r_d;

    logic [PLANES-1:0] allow;
    logic [PLANES-1:0] sel;
    logic              sel_one;
    logic [PIX_W-1:0]  merged;
    logic [PIDX_W-1:0] next_idx;

    vram_readfmt_planesel #(.PLANES(PLANES), .LOW_PLANES(2)) u_planesel (
        .mode      (mode),
        .frame_b   (r_q.cfg[CFG_FRAME_BIT]),
        .hi_fitted (hi_fitted),
        .allow     (allow)
    );

    vram_readfmt_merge #(.PIX_W(PIX_W)) u_merge (
        .acc    (r_q.acc),
        .data   (mem_rdata),
        .tgt    (r_q.tgt[r_q.cap_plane]),
        .srch   (r_q.srch),
        .result (merged)
    );

    assign sel     = r_q.cfg[PLANES-1:0] & allow;
    assign sel_one = ($countones(sel) == 1);

    always_comb begin
        next_idx = '0;
        for (int i = PLANES - 1; i >= 0; i--) begin
            if (r_q.pend[i]) next_idx = PIDX_W'(i);
        end
    end

    always_comb begin
        r_d       = r_q;
        mem_en    = 1'b0;
        mem_plane = '0;
        if (cfg_we) r_d.cfg = cfg_wdata;
        unique case (r_q.st)
            ST_IDLE: begin
                if (rd_req) begin
                    r_d.st   = ST_FETCH;
                    r_d.srch = r_q.cfg[CFG_SRCH_BIT];
                    r_d.tgt  = r_q.cfg[PLANES-1:0];
                    r_d.cap  = 1'b0;
                    if (r_q.cfg[CFG_SRCH_BIT]) begin
                        r_d.pend = allow;
                        r_d.acc  = (allow != '0) ? '1 : '0;
                    end else begin
                        r_d.pend = sel_one ? sel : '0;
                        r_d.acc  = '0;
                    end
                end
            end
            ST_FETCH: begin
                r_d.cap = 1'b0;
                if (r_q.cap) r_d.acc = merged;
                if (r_q.pend != '0) begin
                    if (!mem_busy) begin
                        mem_en                = 1'b1;
                        mem_plane             = next_idx;
                        r_d.pend[next_idx]    = 1'b0;
                        r_d.cap               = 1'b1;
                        r_d.cap_plane         = next_idx;
                    end
                end else if (!r_q.cap) begin
                    r_d.st = ST_DONE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_ack  = (r_q.st == ST_DONE);
    assign rd_data = r_q.acc;
endmodule

// File: rtl/vram_readfmt_chk.sv
module vram_readfmt_chk #(
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_ack,
    input logic          mem_en,
    input logic          mem_busy,
    input logic          hi_fitted,
    input logic [PW-1:0] mem_plane
);
    // R10: no access while the display holds the memory
    p_no_busy_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !mem_busy);

    // R11: acknowledge is a single-cycle pulse
    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !rd_ack);

    // R11: result cannot be ready the cycle after an access
    p_capture_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !rd_ack);

    // R12: missing upper planes are never accessed
    p_hi_absent_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !hi_fitted) |-> (mem_plane < PW'(2)));

    // R1: quiet outputs right after reset release
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!rd_ack && !mem_en));
endmodule

bind vram_readfmt vram_readfmt_chk #(.PW($clog2(PLANES))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_ack    (rd_ack),
    .mem_en    (mem_en),
    .mem_busy  (mem_busy),
    .hi_fitted (hi_fitted),
    .mem_plane (mem_plane)
);

// File: tb/vram_readfmt_bench.sv
module vram_readfmt_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] mode = '0;
    logic       hi_fitted = 1'b1;
    logic       rd_req = 1'b0;
    logic       rd_ack;
    logic [7:0] rd_data;
    logic       mem_busy = 1'b0;
    logic       mem_en;
    logic [1:0] mem_plane;
    logic [7:0] mem_rdata = '0;

    int checks = 0;
    int fails = 0;
    int fetch_cnt = 0;
    int ack_cnt = 0;
    int bcnt = 0;
    bit busy_on = 1'b0;
    logic [7:0] vram [4];

    always #2 clk = ~clk;

    vram_readfmt u_vram_readfmt (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .mode(mode), .hi_fitted(hi_fitted), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_data(rd_data), .mem_busy(mem_busy), .mem_en(mem_en),
        .mem_plane(mem_plane), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= vram[mem_plane];
            fetch_cnt <= fetch_cnt + 1;
        end
        if (rd_ack) ack_cnt <= ack_cnt + 1;
    end

    always @(negedge clk) begin
        bcnt = bcnt + 1;
        mem_busy <= busy_on && ((bcnt % 4) != 0);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] allowed(input logic [1:0] md, input logic fb, input logic hi);
        logic [3:0] m;
        case (md)
            2'd0: m = fb ? 4'b1100 : 4'b0011;
            2'd1: m = fb ? 4'b0010 : 4'b0001;
            2'd2: m = 4'b0101;
            default: m = 4'b1111;
        endcase
        if (!hi) m = m & 4'b0011;
        return m;
    endfunction

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] exp, input int exp_fetch, input string tag);
        int n = 0;
        @(negedge clk);
        fetch_cnt = 0;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        while (!rd_ack && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(rd_ack === 1'b1, {tag, " ack seen"}, rd_ack, 1);
        check(rd_data === exp, {tag, " data"}, rd_data, exp);
        check(fetch_cnt == exp_fetch, {tag, " access count"}, fetch_cnt, exp_fetch);
        @(negedge clk);
        check(rd_ack === 1'b0, "R11 ack one cycle", rd_ack, 0);
    endtask

    // Expected values from the requirement text: allowed set per mode/frame/fit
    task automatic read_model(input logic [7:0] cfg, input string tag);
        logic [3:0] m;
        logic [3:0] s;
        logic [7:0] e;
        int nf;
        m = allowed(mode, cfg[4], hi_fitted);
        if (cfg[7]) begin
            e = (m != 0) ? 8'hFF : 8'h00;
            for (int p = 0; p < 4; p++)
                if (m[p]) e = e & ~(vram[p] ^ {8{cfg[p]}});
            nf = $countones(m);
        end else begin
            s = cfg[3:0] & m;
            e = 8'h00; nf = 0;
            if ($countones(s) == 1) begin
                for (int p = 0; p < 4; p++) if (s[p]) e = vram[p];
                nf = 1;
            end
        end
        write_cfg(cfg);
        do_read(e, nf, tag);
    endtask

    task automatic t_reset();
        check(rd_ack === 1'b0, "R1 ack low after reset", rd_ack, 0);
        check(mem_en === 1'b0, "R1 no access after reset", mem_en, 0);
        do_read(8'h00, 0, "R1 default format read");
    endtask

    task automatic t_single();
        mode = 2'd0;
        write_cfg(8'h01); do_read(8'hA5, 1, "R3 R2 plane I raw");
        read_model(8'h14, "R6 mode0 frame B plane III");
        read_model(8'h12, "R6 mode0 frame B ignores plane II");
        read_model(8'h18, "R6 mode0 frame B plane IV");
        mode = 2'd1;
        read_model(8'h12, "R7 mode1 frame B plane II");
        read_model(8'h11, "R7 mode1 frame B ignores plane I");
        read_model(8'h01, "R7 mode1 frame A plane I");
    endtask

    task automatic t_single_bad();
        mode = 2'd3;
        write_cfg(8'h03); do_read(8'h00, 0, "R4 two planes selected");
        write_cfg(8'h00); do_read(8'h00, 0, "R4 no plane selected");
        hi_fitted = 1'b0;
        write_cfg(8'h04); do_read(8'h00, 0, "R4 R12 absent plane III");
        hi_fitted = 1'b1;
    endtask

    task automatic t_search();
        mode = 2'd0;
        write_cfg(8'h81); do_read(8'h81, 2, "R5 R6 mode0 frame A search");
        read_model(8'h9C, "R6 mode0 frame B search");
        mode = 2'd2;
        write_cfg(8'h85); do_read(8'hA0, 2, "R8 mode2 search I III");
        write_cfg(8'h9F); do_read(8'hA0, 2, "R8 mode2 frame and II IV ignored");
        mode = 2'd3;
        write_cfg(8'h85); do_read(8'h80, 4, "R9 R5 mode3 four-plane search");
        read_model(8'h8A, "R9 mode3 other colour");
    endtask

    task automatic t_hi_absent();
        hi_fitted = 1'b0;
        mode = 2'd3;
        write_cfg(8'h8F); do_read(8'h24, 2, "R12 upper planes dropped");
        mode = 2'd0;
        write_cfg(8'h9F); do_read(8'h00, 0, "R12 empty search set");
        hi_fitted = 1'b1;
    endtask

    task automatic t_busy();
        int a0;
        busy_on = 1'b1;
        mode = 2'd3;
        read_model(8'h8F, "R10 search under busy");
        read_model(8'h08, "R10 single under busy");
        write_cfg(8'h85);
        a0 = ack_cnt;
        @(negedge clk);
        fetch_cnt = 0;
        rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        repeat (3) @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        repeat (60) @(negedge clk);
        check(ack_cnt - a0 == 1, "R11 mid-read request ignored", ack_cnt - a0, 1);
        check(fetch_cnt == 4, "R11 R10 accesses for one read", fetch_cnt, 4);
        check(rd_data === 8'h80, "R11 result held", rd_data, 8'h80);
        busy_on = 1'b0;
    endtask

    initial begin
        vram[0] = 8'hA5; vram[1] = 8'h3C; vram[2] = 8'hF0; vram[3] = 8'h0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_single_bad();
        t_search();
        t_hi_absent();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule